// File: doc/BRIEF.md
# Read/Write Bus Turnaround Arbiter

This block decides, cycle by cycle, whether the shared data bus of one memory channel serves reads or writes. It watches how full the read and write request queues are and walks a four-phase state machine: reading, turning from reads to writes, writing, and turning from writes to reads. Write draining begins once the write queue climbs above a high watermark, or as soon as reads run dry while writes wait. It ends only after a minimum number of writes has gone out and the write queue has fallen to a low watermark. An empty write queue ends it at once.

The scheduler that sits beside it reports each burst it places on the bus with a one-cycle strobe and the burst's direction, and tells the arbiter when no access is in flight. A direction change is only taken while that idle indication is high. The arbiter returns the current phase and a grant that permits bursts only in the two steady phases. Each turnaround lasts a fixed number of cycles, set separately for each direction, and is timed by a down-counter. A per-period burst count is brought out so the scheduler can see how long the current period has run.

Top module: `rw_turn_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, `busPhase` is 0 (reading), `issueGrant` is 1 and `periodCount` is 0.
- R2: `busPhase` encodes the phases as 0 = reading, 1 = read-to-write turnaround, 2 = writing, 3 = write-to-read turnaround. `issueGrant` is 1 exactly in phases 0 and 2.
- R3: In phase 0, with `chanIdle` high and `wrLevel` strictly above `HIGH_MARK`, the next phase is 1. A `wrLevel` equal to `HIGH_MARK` with reads pending keeps phase 0.
- R4: In phase 0, with `chanIdle` high, `rdLevel` zero and `wrLevel` non-zero, the next phase is 1 even below `HIGH_MARK`.
- R5: While `chanIdle` is low, phases 0 and 2 never change, whatever the queue levels.
- R6: Phase 1 lasts exactly `RD2WR_CYCLES` cycles and then phase 2 follows. Strobes seen during it do not change `periodCount`.
- R7: Phase 3 lasts exactly `WR2RD_CYCLES` cycles and then phase 0 follows.
- R8: In phase 2 with `chanIdle` high and `wrLevel` non-zero, the next phase is 3 only when `wrLevel` is at most `LOW_MARK`, `periodCount` is at least `MIN_WRITES` and `rdLevel` is non-zero. Otherwise phase 2 holds.
- R9: In phase 2 with `chanIdle` high and `wrLevel` zero, the next phase is 3 regardless of `periodCount`.
- R10: `periodCount` increments by one (saturating) on each cycle where `burstIssued` is high in a granted phase and `burstIsWrite` matches it (0 in phase 0, 1 in phase 2). A strobe of the wrong direction leaves it unchanged. It is cleared on the edge that leaves phase 0 or 2, and clearing wins over a same-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdLevel | input | LEVEL_W | Entries waiting in the read queue |
| wrLevel | input | LEVEL_W | Entries waiting in the write queue |
| burstIssued | input | 1 | One-cycle strobe: a burst was placed on the bus |
| burstIsWrite | input | 1 | Direction of the strobed burst, 1 = write |
| chanIdle | input | 1 | High when no access is in flight, so a direction change may be taken |
| busPhase | output | 2 | Current phase, encoded as in R2 |
| issueGrant | output | 1 | High when a burst of the current direction may be issued |
| periodCount | output | PERIOD_W | Bursts issued in the current direction period |

## Verification
The bench sits right on each watermark: a write level equal to the high mark must not start a drain, and a level one above the low mark must not end it. A design with an off-by-one comparison would flip direction one entry early. It also tries to leave the writing phase with too few writes and with the read queue empty, where a careless exit rule would hand the bus back with nothing to read. Turnaround lengths are counted cycle by cycle, so a counter loaded with the delay rather than the delay minus one shows up as one extra cycle. Wrong-direction strobes, strobes during a turnaround, and a busy channel beside a full write queue are each driven, and a design that counts them or switches anyway shows it in `periodCount` or `busPhase`.

// File: rtl/rwarb_pkg.sv
package rwarb_pkg;

  // Bus phase; the numeric values are visible on the top-level port.
  typedef enum logic [1:0] {
    PH_READ  = 2'd0,
    PH_RD2WR = 2'd1,
    PH_WRITE = 2'd2,
    PH_WR2RD = 2'd3
  } busPhase_t;

  // Strobes from the control FSM to the counter datapath.
  typedef struct packed {
    logic clrPeriod;
    logic incPeriod;
    logic loadRd2Wr;
    logic loadWr2Rd;
    logic decTurn;
  } ctlStrobe_t;

  // Flags from the datapath back to the control FSM.
  typedef struct packed {
    logic wrAboveHigh;
    logic wrAtOrBelowLow;
    logic wrEmpty;
    logic rdEmpty;
    logic minWritesMet;
    logic turnDone;
  } dpFlags_t;

endpackage

// File: rtl/rwarb_dpath.sv
module rwarb_dpath
  import rwarb_pkg::*;
#(
  parameter int LEVEL_W      = 6,
  parameter int PERIOD_W     = 6,
  parameter int HIGH_MARK    = 12,
  parameter int LOW_MARK     = 4,
  parameter int MIN_WRITES   = 3,
  parameter int RD2WR_CYCLES = 2,
  parameter int WR2RD_CYCLES = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LEVEL_W-1:0]  rdLevel,
  input  logic [LEVEL_W-1:0]  wrLevel,
  input  ctlStrobe_t          ctl,
  output dpFlags_t            flags,
  output logic [PERIOD_W-1:0] periodCount
);

  localparam int TURN_MAX = (RD2WR_CYCLES > WR2RD_CYCLES) ? RD2WR_CYCLES : WR2RD_CYCLES;
  localparam int TURN_W   = (TURN_MAX < 2) ? 1 : $clog2(TURN_MAX);
  localparam logic [TURN_W-1:0]   RD2WR_LOAD = TURN_W'(RD2WR_CYCLES - 1);
  localparam logic [TURN_W-1:0]   WR2RD_LOAD = TURN_W'(WR2RD_CYCLES - 1);
  localparam logic [LEVEL_W-1:0]  HIGH_L     = LEVEL_W'(HIGH_MARK);
  localparam logic [LEVEL_W-1:0]  LOW_L      = LEVEL_W'(LOW_MARK);
  localparam logic [PERIOD_W-1:0] PERIOD_TOP = {PERIOD_W{1'b1}};

  logic [TURN_W-1:0] turnCnt;

  // Turnaround down-counter: loaded with delay-1, state ends when it reads 0.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      turnCnt <= '0;
    end else if (ctl.loadRd2Wr) begin
      turnCnt <= RD2WR_LOAD;
    end else if (ctl.loadWr2Rd) begin
      turnCnt <= WR2RD_LOAD;
    end else if (ctl.decTurn) begin
      turnCnt <= turnCnt - 1'b1;
    end
  end

  // Per-period burst counter, saturating; clear has priority.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCount <= '0;
    end else if (ctl.clrPeriod) begin
      periodCount <= '0;
    end else if (ctl.incPeriod && (periodCount != PERIOD_TOP)) begin
      periodCount <= periodCount + 1'b1;
    end
  end

  // Watermark comparators.
  always_comb begin
    flags.wrAboveHigh    = (wrLevel > HIGH_L);
    flags.wrAtOrBelowLow = (wrLevel <= LOW_L);
    flags.wrEmpty        = (wrLevel == '0);
    flags.rdEmpty        = (rdLevel == '0);
    flags.turnDone       = (turnCnt == '0);
  end

  generate
    if (MIN_WRITES <= 0) begin : g_noMin
      assign flags.minWritesMet = 1'b1;
    end else begin : g_min
      localparam logic [PERIOD_W-1:0] MIN_L = PERIOD_W'(MIN_WRITES);
      assign flags.minWritesMet = (periodCount >= MIN_L);
    end
  endgenerate

  // R6: the FSM never asks to count below zero.
  assert_turn_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.decTurn |-> (turnCnt != '0));

  // R10: a clear request leaves the period count at zero.
  assert_period_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrPeriod |=> (periodCount == '0));

  // R10: a counted burst advances the count by exactly one.
  assert_period_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.incPeriod && !ctl.clrPeriod && (periodCount != PERIOD_TOP))
      |=> (periodCount == $past(periodCount) + 1'b1));

endmodule

// File: rtl/rwarb_ctrl.sv
module rwarb_ctrl
  import rwarb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       burstIssued,
  input  logic       burstIsWrite,
  input  logic       chanIdle,
  input  dpFlags_t   flags,
  output ctlStrobe_t ctl,
  output busPhase_t  phase,
  output logic       issueGrant
);

  busPhase_t nextPhase;
  logic      startDrain;
  logic      endDrain;

  always_comb begin
    startDrain = chanIdle &&
                 (flags.wrAboveHigh || (flags.rdEmpty && !flags.wrEmpty));
    endDrain   = chanIdle &&
                 (flags.wrEmpty ||
                  (flags.wrAtOrBelowLow && flags.minWritesMet && !flags.rdEmpty));
  end

  always_comb begin
    nextPhase = phase;
    ctl       = '0;
    unique case (phase)
      PH_READ: begin
        if (startDrain) begin
          nextPhase     = PH_RD2WR;
          ctl.clrPeriod = 1'b1;
          ctl.loadRd2Wr = 1'b1;
        end else if (burstIssued && !burstIsWrite) begin
          ctl.incPeriod = 1'b1;
        end
      end
      PH_RD2WR: begin
        if (flags.turnDone) nextPhase = PH_WRITE;
        else                ctl.decTurn = 1'b1;
      end
      PH_WRITE: begin
        if (endDrain) begin
          nextPhase     = PH_WR2RD;
          ctl.clrPeriod = 1'b1;
          ctl.loadWr2Rd = 1'b1;
        end else if (burstIssued && burstIsWrite) begin
          ctl.incPeriod = 1'b1;
        end
      end
      PH_WR2RD: begin
        if (flags.turnDone) nextPhase = PH_READ;
        else                ctl.decTurn = 1'b1;
      end
      default: nextPhase = PH_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_READ;
    else       phase <= nextPhase;
  end

  always_comb issueGrant = (phase == PH_READ) || (phase == PH_WRITE);

  // R5: a busy channel pins the steady phases.
  assert_hold_when_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_READ || phase == PH_WRITE) && !chanIdle) |=> (phase == $past(phase)));

  // R2: from reading only reading or the read-to-write turnaround may follow.
  assert_read_exit_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_READ) |=> (phase == PH_READ || phase == PH_RD2WR));

  // R6: writing is entered only after the turnaround counter ran out.
  assert_turn_finished_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WRITE && $past(phase) == PH_RD2WR) |-> $past(flags.turnDone));

  // R8: leaving writing needs an empty queue or low mark plus enough writes.
  assert_drain_exit_R8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WR2RD && $past(phase) == PH_WRITE)
      |-> $past(flags.wrEmpty || (flags.wrAtOrBelowLow && flags.minWritesMet)));

endmodule

// File: rtl/rw_turn_arbiter.sv
module rw_turn_arbiter
  import rwarb_pkg::*;
#(
  parameter int LEVEL_W      = 6,
  parameter int PERIOD_W     = 6,
  parameter int HIGH_MARK    = 12,
  parameter int LOW_MARK     = 4,
  parameter int MIN_WRITES   = 3,
  parameter int RD2WR_CYCLES = 2,
  parameter int WR2RD_CYCLES = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [LEVEL_W-1:0]  rdLevel,
  input  logic [LEVEL_W-1:0]  wrLevel,
  input  logic                burstIssued,
  input  logic                burstIsWrite,
  input  logic                chanIdle,
  output logic [1:0]          busPhase,
  output logic                issueGrant,
  output logic [PERIOD_W-1:0] periodCount
);

  ctlStrobe_t ctl;
  dpFlags_t   flags;
  busPhase_t  phase;

  rwarb_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .burstIssued  (burstIssued),
    .burstIsWrite (burstIsWrite),
    .chanIdle     (chanIdle),
    .flags        (flags),
    .ctl          (ctl),
    .phase        (phase),
    .issueGrant   (issueGrant)
  );

  rwarb_dpath #(
    .LEVEL_W      (LEVEL_W),
    .PERIOD_W     (PERIOD_W),
    .HIGH_MARK    (HIGH_MARK),
    .LOW_MARK     (LOW_MARK),
    .MIN_WRITES   (MIN_WRITES),
    .RD2WR_CYCLES (RD2WR_CYCLES),
    .WR2RD_CYCLES (WR2RD_CYCLES)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .rdLevel     (rdLevel),
    .wrLevel     (wrLevel),
    .ctl         (ctl),
    .flags       (flags),
    .periodCount (periodCount)
  );

  assign busPhase = phase;

endmodule

// File: tb/rw_turn_arbiter_bench.sv
`timescale 1ns/1ps
module rw_turn_arbiter_bench;

  localparam int LEVEL_W = 6, PERIOD_W = 6, HIGH_MARK = 12, LOW_MARK = 4;
  localparam int MIN_WRITES = 3, RD2WR_CYCLES = 2, WR2RD_CYCLES = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LEVEL_W-1:0] rdLevel = '0, wrLevel = '0;
  logic burstIssued = 1'b0, burstIsWrite = 1'b0, chanIdle = 1'b1;
  logic [1:0] busPhase;
  logic issueGrant;
  logic [PERIOD_W-1:0] periodCount;

  always #4 clk = ~clk;

  rw_turn_arbiter #(
    .LEVEL_W(LEVEL_W), .PERIOD_W(PERIOD_W), .HIGH_MARK(HIGH_MARK),
    .LOW_MARK(LOW_MARK), .MIN_WRITES(MIN_WRITES),
    .RD2WR_CYCLES(RD2WR_CYCLES), .WR2RD_CYCLES(WR2RD_CYCLES)
  ) u_rw_turn_arbiter (
    .clk(clk), .rstN(rstN), .rdLevel(rdLevel), .wrLevel(wrLevel),
    .burstIssued(burstIssued), .burstIsWrite(burstIsWrite), .chanIdle(chanIdle),
    .busPhase(busPhase), .issueGrant(issueGrant), .periodCount(periodCount)
  );

  typedef struct {
    int    phase;
    int    grant;
    int    count;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state, kept from the requirements.
  int mPhase = 0, mCount = 0, mTurn = 0;

  task automatic compare(input string tag, input int ph, input int gn, input int ct);
    checks++;
    if (int'(busPhase) != ph || int'(issueGrant) != gn || int'(periodCount) != ct) begin
      errors++;
      $display("FAIL %s: phase/grant/count actual %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, busPhase, issueGrant, periodCount, ph, gn, ct);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected post-edge state.
  task automatic step(input int rd, input int wr, input bit iss, input bit isW,
                      input bit idle, input string tag);
    expItem_t e;
    @(negedge clk);
    rdLevel = LEVEL_W'(rd); wrLevel = LEVEL_W'(wr);
    burstIssued = iss; burstIsWrite = isW; chanIdle = idle;
    case (mPhase)
      0: if (idle && (wr > HIGH_MARK || (rd == 0 && wr != 0))) begin
           mPhase = 1; mCount = 0; mTurn = RD2WR_CYCLES - 1;
         end else if (iss && !isW && mCount < 63) mCount++;
      1: if (mTurn == 0) mPhase = 2; else mTurn--;
      2: if (idle && (wr == 0 || (wr <= LOW_MARK && mCount >= MIN_WRITES && rd != 0))) begin
           mPhase = 3; mCount = 0; mTurn = WR2RD_CYCLES - 1;
         end else if (iss && isW && mCount < 63) mCount++;
      default: if (mTurn == 0) mPhase = 0; else mTurn--;
    endcase
    e.phase = mPhase;
    e.grant = (mPhase == 0 || mPhase == 2) ? 1 : 0;
    e.count = mCount;
    e.tag   = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compare after each edge, away from it.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        compare(e.tag, e.phase, e.grant, e.count);
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset", 0, 1, 0);
    rstN = 1'b1;
    @(posedge clk); #2;
    compare("R1 after reset", 0, 1, 0);

    // R10: reads counted, wrong-direction strobe ignored.
    step(5, 0, 1, 0, 1, "R10 read count 1");
    step(5, 0, 1, 0, 1, "R10 read count 2");
    step(5, 0, 1, 1, 1, "R10 write strobe ignored in read");
    step(5, 0, 1, 0, 1, "R10 read count 3");
    // R5: busy channel holds phase 0 even above the high mark.
    step(5, 13, 0, 0, 0, "R5 busy hold read");
    step(5, 20, 0, 0, 0, "R5 busy hold read 2");
    // R3: equal to the high mark does not switch; one above does.
    step(5, 12, 0, 0, 1, "R3 at high mark stays");
    step(5, 13, 1, 0, 1, "R3 above high mark switches, clear wins R10");
    // R6: turnaround length, strobes ignored.
    step(5, 13, 1, 1, 1, "R6 turnaround strobe ignored");
    step(5, 13, 0, 0, 1, "R6 turnaround ends R2");
    // R8: write period.
    step(5, 10, 1, 1, 1, "R10 write count 1");
    step(5, 4, 1, 0, 1, "R10 read strobe ignored in write");
    step(5, 4, 1, 1, 1, "R8 low mark but few writes");
    step(5, 10, 1, 1, 1, "R10 write count 3");
    step(5, 5, 0, 0, 0, "R5 busy hold write");
    step(5, 5, 0, 0, 1, "R8 one above low mark stays");
    step(0, 4, 0, 0, 1, "R8 reads empty stays");
    step(5, 4, 0, 0, 1, "R8 drain ends");
    // R7: write-to-read turnaround.
    step(5, 4, 1, 0, 1, "R7 turnaround 2");
    step(5, 4, 0, 0, 1, "R7 turnaround 3");
    step(5, 4, 0, 0, 1, "R7 back to read R2");
    // R4: no reads, a write below the mark.
    step(0, 1, 0, 0, 1, "R4 reads empty switch");
    step(0, 1, 0, 0, 1, "R6 turnaround");
    step(0, 1, 0, 0, 1, "R6 enter write");
    // R9: empty write queue ends draining with no writes done.
    step(3, 0, 0, 0, 1, "R9 write queue empty exit");
    step(3, 0, 0, 0, 1, "R7 turnaround");
    step(3, 0, 0, 0, 1, "R7 turnaround");
    step(3, 0, 1, 0, 1, "R7 read again");
    step(3, 0, 1, 0, 1, "R10 read count after return");
    @(negedge clk);
    burstIssued = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule